// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Service

This block is a watchdog timer whose counter runs on its own time base, a clock separate from the bus clock. Software keeps it alive by writing a two-value key to an arm register. If no valid service arrives before the period runs out, the block raises a reset request. It also raises one for a service that comes too early while window mode is on, and at once for any wrong key value. The reset sequencer outside the block consumes the request and resets the chip.

The timeout select and the window enable are loaded from a non-volatile configuration nibble during reset, so the counter runs before any software action. Software may replace the configuration once after each reset; later writes are ignored. That single write can also do two things. It can let an active debug session freeze the count. It can let stop mode gate the watchdog clock. Both options are off after reset.

A sticky cause flag records that the watchdog made the request and survives every reset except power-on. Service writes, configuration and mode inputs cross into the counter domain through two-flop synchronizers. Expiry and acknowledge come back the same way. A service is acknowledged once the counter domain has seen it.

Top module: `wdt_keyed`

## Requirements
- R1: A write to the arm register of any value other than 0x55, or of 0xAA not preceded by an arming 0x55, asserts `rst_req` at the next bus clock edge.
- R2: Writing 0x55 then 0xAA restarts the count. After the counter domain has taken the service, `svc_ack` is high for exactly one bus cycle, once per service.
- R3: Without a valid service, the counter expires after 2^(BASE_LOG+tsel) watchdog clock cycles and `rst_req` is asserted; tsel is configuration bits [2:0].
- R4: With window mode on (configuration bit 3), a service taken while the count is below three quarters of the period asserts `rst_req`. A service in the last quarter restarts the count.
- R5: Once asserted, `rst_req` stays high until `rst` or `por`.
- R6: `cause_wdt` is set whenever `rst_req` is set, is kept through `rst`, and is cleared only by `por`.
- R7: During reset, tsel and the window enable are taken from `cfg_nv[2:0]` and `cfg_nv[3]`, and counting starts after reset without any write.
- R8: Only the first `cfg_wr` after a reset takes effect, with layout [2:0] tsel, [3] window enable, [4] freeze in debug, [5] gate in stop. Later writes leave the configuration unchanged.
- R9: With bit 4 clear (its reset value) the count keeps running while `dbg_active` is high. With bit 4 set, `dbg_active` holds the count.
- R10: With bit 5 clear (its reset value) the count keeps running while `stop_mode` is high. With bit 5 set, `stop_mode` holds the count.
- R11: While `rst` or `por` is applied, `rst_req` and `svc_ack` are low after the next bus clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| wclk | input | 1 | Independent watchdog time base |
| rst | input | 1 | Synchronous system reset, active high |
| por | input | 1 | Synchronous power-on reset, active high; also clears the cause flag |
| cfg_nv | input | 4 | Non-volatile configuration loaded at reset: [2:0] tsel, [3] window enable |
| cfg_wr | input | 1 | Write strobe for the one-time configuration |
| cfg_wdata | input | 6 | Configuration data: [2:0] tsel, [3] window, [4] freeze in debug, [5] gate in stop |
| wr_en | input | 1 | Write strobe for the arm register |
| wr_data | input | 8 | Key value written to the arm register |
| dbg_active | input | 1 | Debug session holds the processor |
| stop_mode | input | 1 | Chip is in stop mode |
| rst_req | output | 1 | Reset request to the reset sequencer, latched |
| cause_wdt | output | 1 | Sticky flag: the watchdog requested a reset |
| svc_ack | output | 1 | One-cycle pulse when a service has reached the counter domain |

## Verification
A valid service and counter expiry can land in the same watchdog cycle. The counter domain then lets the service decide: it restarts the count, or it flags an early service. The bench provokes this with a vector table that places the key write on either side of the deadline and of the window opening, for several timeout selects. It judges each case by the level of `rst_req` a few cycles later and by the acknowledge count. The placements keep a margin of several watchdog cycles to cover synchronizer latency. A wrong key can also meet an expiry that is crossing over. Both set the same latched request and cause flag, which the bad-key and timeout cases check.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

    typedef struct packed {
        logic       stop_gate;
        logic       dbg_freeze;
        logic       win_en;
        logic [2:0] tsel;
    } wdt_cfg_t;

    localparam int CFG_W = $bits(wdt_cfg_t);

    typedef enum logic [1:0] {
        KEY_K_ARM  = 2'd0,
        KEY_K_FIRE = 2'd1,
        KEY_K_BAD  = 2'd2
    } key_kind_e;

    // Last count value before expiry: period minus one
    function automatic logic [31:0] tmo_last(input int base_log, input logic [2:0] tsel);
        return (32'd1 << (base_log + int'(tsel))) - 32'd1;
    endfunction

    // First count value inside the open window (last quarter of the period)
    function automatic logic [31:0] win_open(input logic [31:0] last);
        logic [31:0] per;
        per = last + 32'd1;
        return per - (per >> 2);
    endfunction

    function automatic key_kind_e classify(input logic [7:0] data, input logic armed);
        if (data == KEY_ARM)               return KEY_K_ARM;
        else if (data == KEY_FIRE && armed) return KEY_K_FIRE;
        else                                return KEY_K_BAD;
    endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int BASE_LOG = 4
) (
    input  logic     wclk,
    input  logic     rst_w,
    input  wdt_cfg_t cfg_w,
    input  logic     dbg_w,
    input  logic     stop_w,
    input  logic     svc_tgl_w,
    output logic     ack_tgl,
    output logic     expired
);
    localparam int CNT_W = BASE_LOG + 8;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_c;
    logic [CNT_W-1:0] open_c;
    logic             svc_seen;
    logic             hold;
    logic             early;

    always_comb begin
        last_c = CNT_W'(tmo_last(BASE_LOG, cfg_w.tsel));
        open_c = CNT_W'(win_open(tmo_last(BASE_LOG, cfg_w.tsel)));
        hold   = (cfg_w.dbg_freeze & dbg_w) | (cfg_w.stop_gate & stop_w);
        early  = cfg_w.win_en & (cnt < open_c);
    end

    always_ff @(posedge wclk) begin
        if (rst_w) begin
            cnt      <= '0;
            svc_seen <= 1'b0;
            ack_tgl  <= 1'b0;
            expired  <= 1'b0;
        end else if (svc_tgl_w != svc_seen) begin
            // a service taken this cycle outranks expiry
            svc_seen <= svc_tgl_w;
            ack_tgl  <= ~ack_tgl;
            if (early) expired <= 1'b1;
            else       cnt     <= '0;
        end else if (!hold && !expired) begin
            if (cnt >= last_c) expired <= 1'b1;
            else               cnt     <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdt_bus.sv
module wdt_bus
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             por,
    input  logic [3:0]       cfg_nv,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             exp_b,
    input  logic             ack_b,
    output logic             rst_req,
    output logic             cause_wdt,
    output logic             svc_ack,
    output logic             svc_tgl,
    output wdt_cfg_t         cfg_q,
    output logic             cfg_locked
);
    logic      armed;
    logic      busy;
    logic      ack_seen;
    logic      bad;
    key_kind_e kind;

    always_comb begin
        kind = classify(wr_data, armed);
        bad  = wr_en && (kind == KEY_K_BAD);
    end

    always_ff @(posedge clk) begin
        if (rst || por) begin
            armed      <= 1'b0;
            svc_tgl    <= 1'b0;
            busy       <= 1'b0;
            ack_seen   <= 1'b0;
            rst_req    <= 1'b0;
            svc_ack    <= 1'b0;
            cfg_locked <= 1'b0;
            cfg_q      <= '{stop_gate: 1'b0, dbg_freeze: 1'b0,
                            win_en: cfg_nv[3], tsel: cfg_nv[2:0]};
        end else begin
            svc_ack  <= (ack_b != ack_seen);
            ack_seen <= ack_b;
            if (ack_b != ack_seen) busy <= 1'b0;
            if (wr_en) begin
                unique case (kind)
                    KEY_K_ARM:  armed <= 1'b1;
                    KEY_K_FIRE: begin
                        armed <= 1'b0;
                        if (!busy) begin
                            svc_tgl <= ~svc_tgl;
                            busy    <= 1'b1;
                        end
                    end
                    default:    armed <= 1'b0;
                endcase
            end
            if (bad || exp_b) rst_req <= 1'b1;
            if (cfg_wr && !cfg_locked) begin
                cfg_q      <= wdt_cfg_t'(cfg_wdata);
                cfg_locked <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (por)                        cause_wdt <= 1'b0;
        else if (!rst && (bad || exp_b)) cause_wdt <= 1'b1;
    end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int BASE_LOG    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             wclk,
    input  logic             rst,
    input  logic             por,
    input  logic [3:0]       cfg_nv,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             dbg_active,
    input  logic             stop_mode,
    output logic             rst_req,
    output logic             cause_wdt,
    output logic             svc_ack
);
    localparam int FWD_W = CFG_W + 4;

    wdt_cfg_t         cfg_q;
    wdt_cfg_t         cfg_w;
    logic             cfg_locked;
    logic             svc_tgl;
    logic [FWD_W-1:0] fwd_w;
    logic             rst_w;
    logic             dbg_w;
    logic             stop_w;
    logic             svc_tgl_w;
    logic             ack_tgl;
    logic             expired;
    logic [1:0]       back_b;

    wdt_sync #(.W(FWD_W), .STAGES(SYNC_STAGES)) i_fwd_sync (
        .clk (wclk),
        .d   ({rst | por, dbg_active, stop_mode, svc_tgl, cfg_q}),
        .q   (fwd_w)
    );

    assign {rst_w, dbg_w, stop_w, svc_tgl_w} = fwd_w[FWD_W-1:CFG_W];
    assign cfg_w = wdt_cfg_t'(fwd_w[CFG_W-1:0]);

    wdt_core #(.BASE_LOG(BASE_LOG)) i_core (
        .wclk      (wclk),
        .rst_w     (rst_w),
        .cfg_w     (cfg_w),
        .dbg_w     (dbg_w),
        .stop_w    (stop_w),
        .svc_tgl_w (svc_tgl_w),
        .ack_tgl   (ack_tgl),
        .expired   (expired)
    );

    wdt_sync #(.W(2), .STAGES(SYNC_STAGES)) i_back_sync (
        .clk (clk),
        .d   ({expired, ack_tgl}),
        .q   (back_b)
    );

    wdt_bus i_bus (
        .clk        (clk),
        .rst        (rst),
        .por        (por),
        .cfg_nv     (cfg_nv),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .exp_b      (back_b[1]),
        .ack_b      (back_b[0]),
        .rst_req    (rst_req),
        .cause_wdt  (cause_wdt),
        .svc_ack    (svc_ack),
        .svc_tgl    (svc_tgl),
        .cfg_q      (cfg_q),
        .cfg_locked (cfg_locked)
    );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk (
    input logic       clk,
    input logic       rst,
    input logic       por,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rst_req,
    input logic       cause_wdt,
    input logic       svc_ack,
    input logic       cfg_locked,
    input logic [5:0] cfg_q
);
    a_r1_bad_key: assert property (@(posedge clk) disable iff (rst || por)
        (wr_en && wr_data != 8'h55 && wr_data != 8'hAA) |=> rst_req);

    a_r5_req_holds: assert property (@(posedge clk) disable iff (rst || por)
        rst_req |=> rst_req);

    a_r6_cause_with_req: assert property (@(posedge clk) disable iff (rst || por)
        rst_req |-> cause_wdt);

    a_r6_cause_sticky: assert property (@(posedge clk) disable iff (por)
        cause_wdt |=> cause_wdt);

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst || por)
        cfg_locked |=> $stable(cfg_q));

    a_r2_ack_single: assert property (@(posedge clk) disable iff (rst || por)
        svc_ack |=> !svc_ack);

    a_r11_reset_quiet: assert property (@(posedge clk)
        (rst || por) |=> (!rst_req && !svc_ack));
endmodule

bind wdt_keyed wdt_keyed_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .por        (por),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rst_req    (rst_req),
    .cause_wdt  (cause_wdt),
    .svc_ack    (svc_ack),
    .cfg_locked (cfg_locked),
    .cfg_q      (cfg_q)
);

// File: tb/test_wdt_keyed.sv
`timescale 1ns/1ps
module test_wdt_keyed;
    localparam int BASE = 4;
    localparam int NV   = 10;
    // timeout select, window enable, service delay in watchdog cycles
    localparam int V_TSEL [NV] = '{0, 0, 0, 1, 2, 2, 2, 2, 3, 3};
    localparam int V_WIN  [NV] = '{0, 0, 1, 0, 0, 1, 1, 0, 1, 1};
    localparam int V_DLY  [NV] = '{8, 30, 4, 20, 30, 30, 56, 80, 70, 110};

    logic       clk = 1'b0;
    logic       wclk = 1'b0;
    logic       rst = 1'b1;
    logic       por = 1'b1;
    logic [3:0] cfg_nv = 4'd0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_wdata = 6'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       dbg_active = 1'b0;
    logic       stop_mode = 1'b0;
    logic       rst_req;
    logic       cause_wdt;
    logic       svc_ack;

    int nchk = 0;
    int nfail = 0;
    int ack_cnt = 0;

    always #4  clk  = ~clk;
    always #10 wclk = ~wclk;

    wdt_keyed #(.BASE_LOG(BASE)) i_wdt_keyed (
        .clk(clk), .wclk(wclk), .rst(rst), .por(por), .cfg_nv(cfg_nv),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .wr_en(wr_en), .wr_data(wr_data),
        .dbg_active(dbg_active), .stop_mode(stop_mode),
        .rst_req(rst_req), .cause_wdt(cause_wdt), .svc_ack(svc_ack)
    );

    always @(negedge clk) if (svc_ack) ack_cnt++;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic p);
        @(negedge clk);
        rst = 1'b1; por = p; wr_en = 1'b0; cfg_wr = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b0; por = 1'b0;
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(posedge wclk);
        @(negedge clk);
    endtask

    task automatic wr_key(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic service();
        wr_key(8'h55);
        wr_key(8'hAA);
    endtask

    task automatic wr_cfg(input logic [5:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not end)");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int a0;
        do_reset(1'b1);
        @(negedge clk);
        chk("R11 rst_req after reset", int'(rst_req), 0);
        chk("R11 svc_ack after reset", int'(svc_ack), 0);
        chk("R6 cause after por", int'(cause_wdt), 0);

        // vector table: service placed around deadline and window
        for (int i = 0; i < NV; i++) begin
            int  p, op;
            logic e_tmo, e_early;
            string tag;
            p  = (1 << BASE) << V_TSEL[i];
            op = p - p / 4;
            e_tmo   = (V_DLY[i] >= p);
            e_early = (V_WIN[i] != 0) && (V_DLY[i] < op);
            tag = e_tmo ? "R3 timeout" : (e_early ? "R4 early service" : "R2 in-time service");
            cfg_nv = 4'(V_WIN[i] * 8 + V_TSEL[i]);
            do_reset(1'b0);
            a0 = ack_cnt;
            wcyc(V_DLY[i]);
            service();
            wcyc(10);
            chk(tag, int'(rst_req), int'(e_tmo || e_early));
            if (!e_tmo && !e_early) chk("R2 ack seen", ack_cnt - a0, 1);
        end

        // R1 wrong key, R5 hold, R6 cause behaviour
        cfg_nv = 4'd3;
        do_reset(1'b1);
        wcyc(2);
        chk("R1 before bad key", int'(rst_req), 0);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h3C;
        @(negedge clk); wr_en = 1'b0;
        chk("R1 bad key next cycle", int'(rst_req), 1);
        chk("R6 cause on bad key", int'(cause_wdt), 1);
        wcyc(20);
        chk("R5 request held", int'(rst_req), 1);
        do_reset(1'b0);
        @(negedge clk);
        chk("R5 request cleared by rst", int'(rst_req), 0);
        chk("R6 cause kept over rst", int'(cause_wdt), 1);
        do_reset(1'b1);
        @(negedge clk);
        chk("R6 cause cleared by por", int'(cause_wdt), 0);

        // R1 unarmed 0xAA
        do_reset(1'b0);
        wcyc(2);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hAA;
        @(negedge clk); wr_en = 1'b0;
        chk("R1 unarmed 0xAA", int'(rst_req), 1);

        // R2 continuous servicing
        cfg_nv = 4'd0;
        do_reset(1'b0);
        a0 = ack_cnt;
        for (int k = 0; k < 25; k++) begin
            wcyc(8);
            service();
        end
        wcyc(6);
        chk("R2 kept alive", int'(rst_req), 0);
        chk("R2 one ack per service", ack_cnt - a0, 25);

        // R7 runs from nv configuration without software (tsel 1 -> 32)
        cfg_nv = 4'd1;
        do_reset(1'b0);
        wcyc(20);
        chk("R7 not yet expired", int'(rst_req), 0);
        wcyc(25);
        chk("R7 expired from nv period", int'(rst_req), 1);

        // R8 write-once configuration
        cfg_nv = 4'd0;
        do_reset(1'b0);
        wr_cfg(6'b000011);
        wr_cfg(6'b000000);
        wcyc(60);
        chk("R8 first write took, second ignored", int'(rst_req), 0);
        wcyc(90);
        chk("R8 expiry on first write period", int'(rst_req), 1);

        // R9 debug freeze
        do_reset(1'b0);
        dbg_active = 1'b1;
        wcyc(30);
        chk("R9 runs in debug by default", int'(rst_req), 1);
        do_reset(1'b0);
        wr_cfg(6'b010000);
        wcyc(60);
        chk("R9 frozen in debug", int'(rst_req), 0);
        dbg_active = 1'b0;
        wcyc(30);
        chk("R9 resumes after debug", int'(rst_req), 1);

        // R10 stop gating
        do_reset(1'b0);
        stop_mode = 1'b1;
        wcyc(30);
        chk("R10 runs in stop by default", int'(rst_req), 1);
        do_reset(1'b0);
        wr_cfg(6'b100000);
        wcyc(60);
        chk("R10 gated in stop", int'(rst_req), 0);
        stop_mode = 1'b0;
        wcyc(30);
        chk("R10 resumes after stop", int'(rst_req), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule